// File: doc/BRIEF.md
# Multiplexed LCD Segment Waveform Sequencer

This block produces the drive waveforms for the common (COM) and segment (SEG) lines of a multiplexed segment LCD. It can drive the panel in static mode or multiplexed 2, 3 or 4 ways, at either 1/2 or 1/3 bias. Each output is a 2-bit level code. An analog buffer outside the block turns that code into one of the bias voltages. All timing comes from `refTick`, a one-cycle pulse in the system clock domain for each edge of a 32768 Hz reference. A programmable divider sets the rate at which the waveform steps through its half-slots.

Software uses one byte-wide register write port. Address 0 holds the configuration byte: clock select, mode, enable and blink rate. Each segment has its own byte, which holds a 4-bit pixel word (one bit per COM time slot) and a 4-bit blink mask. Marked pixels are forced off during the off half of a 1 Hz or 0.5 Hz blink period. The segment bytes keep their contents while the display is off and can always be read back. Software may therefore use them as general storage.

Top module: `lcdWaveSeq`

## Requirements
- R1: The configuration byte at address 0 holds clkSel in bits [1:0]. Each half-slot lasts 2^(9-clkSel) refTick pulses: 512, 256, 128 or 64 for codes 0 to 3.
- R2: The mode field sits in configuration bits [4:2]. Its codes are: 000 = 4 slots at 1/3 bias, 001 = 3 slots at 1/3 bias, 010 = 2 slots at 1/2 bias, 011 = 3 slots at 1/2 bias, 100 = static. Codes 101, 110 and 111 behave exactly like static.
- R3: Level codes are 0 = ground, 1 = low intermediate, 2 = high intermediate, 3 = full scale. At 1/3 bias, in the first half of a slot the selected COM is 3 and the other COMs are 1; an on SEG is 0 and an off SEG is 2. In the second half the selected COM is 0 and the other COMs are 2; an on SEG is 3 and an off SEG is 1.
- R4: At 1/2 bias, in the first half of a slot the selected COM is 3 and the other COMs are 1; an on SEG is 0 and an off SEG is 3. In the second half the selected COM is 0 and the other COMs stay at 1; an on SEG is 3 and an off SEG is 0.
- R5: In static drive, COM0 is 3 in the first half and 0 in the second half, and COM1 to COM3 stay at 0. An on SEG takes the opposite level to COM0, and an off SEG takes the same level as COM0. Pixel bit 0 is used.
- R6: Slots run in order from 0 to N-1 and then wrap, with the first half of each slot before the second. COMk is selected in slot k, and SEG uses pixel bit k during slot k. In multiplexed modes, a COM line above N-1 stays at the unselected level.
- R7: While the enable bit (configuration bit 5) is 0, every COM and SEG code is 0 and vlcEn is 0. Enabling the display starts at slot 0, first half, with the blink timer in its on phase.
- R8: Segment byte bits [7:4] form a blink mask, with bit 4 for COM0 up to bit 7 for COM3. A marked pixel is forced off during the blink off phase. The rate bit (configuration bit 6) set to 0 gives on and off phases of 16384 refTick pulses each. Set to 1, it gives 32768 pulses each.
- R9: Blinking does not affect a pixel whose data bit is 0. A mask bit for a COM other than the current slot's COM has no effect either.
- R10: Segment i is written and read at address 16+i. Bits [3:0] hold the pixel word, with bit k for slot k. rdData returns the stored byte whatever the enable state. A write to an address that maps to no register changes nothing.
- R11: After reset, the configuration and all segment bytes are 0, and every output code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One pulse per 32768 Hz reference edge |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| comOut | output | 8 | Four 2-bit COM level codes, COM0 in bits [1:0] |
| segOut | output | 2*NUM_SEG | 2-bit SEG level codes, segment 0 in bits [1:0] |
| vlcEn | output | 1 | Bias ladder enable, high while the display is enabled |

## Verification
The hardest behaviour to reach is the blink boundary. It needs tens of thousands of reference pulses, and the forced-off pixel must be told apart from the normal alternation of the drive polarity. The bench holds refTick high on every cycle and uses static mode. There the pixel state can be read directly: the pixel is on exactly when the SEG code differs from the COM0 code. The bench checks one pulse before and one pulse after each phase edge, at both blink rates. It also checks masks set for other COM lines and pixels whose data bit is off.

// File: rtl/lcdSeqPkg.sv
package lcdSeqPkg;

  localparam int CFG_W   = 7;
  localparam int NUM_COM = 4;

  localparam logic [1:0] LVL_GND = 2'd0;
  localparam logic [1:0] LVL_LO  = 2'd1;
  localparam logic [1:0] LVL_HI  = 2'd2;
  localparam logic [1:0] LVL_TOP = 2'd3;

  // Sequencer state handed from control to datapath
  typedef struct packed {
    logic       enable;
    logic       third;     // 1/3 bias when set, else 1/2
    logic       isStatic;
    logic [2:0] slotCount;
    logic [1:0] slot;
    logic       phase;     // 0 = first half-slot, 1 = second
    logic       blinkOff;
  } seqState_t;

  function automatic logic [2:0] slotsForMode(input logic [2:0] mode);
    case (mode)
      3'b000:  return 3'd4;
      3'b001:  return 3'd3;
      3'b010:  return 3'd2;
      3'b011:  return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/lcdSeqCtrl.sv
module lcdSeqCtrl
  import lcdSeqPkg::*;
#(
  parameter int DIV_BASE_LOG2   = 9,
  parameter int BLINK_FAST_HALF = 16384,
  parameter int BLINK_SLOW_HALF = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgQ,
  output seqState_t        st
);

  localparam int DIV_W   = DIV_BASE_LOG2 + 1;
  localparam int BLINK_W = $clog2(BLINK_SLOW_HALF) + 1;

  logic [1:0]         clkSel;
  logic [2:0]         mode;
  logic               enable;
  logic               rateSlow;
  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   divLimit;
  logic [BLINK_W-1:0] blinkCnt;
  logic [BLINK_W-1:0] blinkLimit;
  logic [2:0]         slotCount;
  logic [2:0]         lastSlotWide;
  logic [1:0]         lastSlot;
  logic [1:0]         slot;
  logic               phase;
  logic               blinkOff;
  logic               advance;

  assign clkSel   = cfgQ[1:0];
  assign mode     = cfgQ[4:2];
  assign enable   = cfgQ[5];
  assign rateSlow = cfgQ[6];

  always_ff @(posedge clk) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgWrData;
  end

  assign divLimit     = DIV_W'((32'd1 << (DIV_BASE_LOG2 - 32'(clkSel))) - 32'd1);
  assign blinkLimit   = rateSlow ? BLINK_W'(BLINK_SLOW_HALF - 1) : BLINK_W'(BLINK_FAST_HALF - 1);
  assign slotCount    = slotsForMode(mode);
  assign lastSlotWide = slotCount - 3'd1;
  assign lastSlot     = lastSlotWide[1:0];
  assign advance      = refTick && (divCnt >= divLimit);

  // Half-slot sequencer
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      divCnt <= '0;
      slot   <= '0;
      phase  <= 1'b0;
    end else if (slot > lastSlot) begin
      slot <= '0;   // mode shrank under a running sequence
    end else if (refTick) begin
      if (advance) begin
        divCnt <= '0;
        phase  <= ~phase;
        if (phase) slot <= (slot == lastSlot) ? 2'd0 : slot + 2'd1;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  // Blink timer
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      blinkCnt <= '0;
      blinkOff <= 1'b0;
    end else if (refTick) begin
      if (blinkCnt >= blinkLimit) begin
        blinkCnt <= '0;
        blinkOff <= ~blinkOff;
      end else begin
        blinkCnt <= blinkCnt + BLINK_W'(1);
      end
    end
  end

  always_comb begin
    st.enable    = enable;
    st.third     = (mode == 3'b000) || (mode == 3'b001);
    st.isStatic  = (slotCount == 3'd1);
    st.slotCount = slotCount;
    st.slot      = slot;
    st.phase     = phase;
    st.blinkOff  = blinkOff;
  end

  // R1: without a reference pulse the waveform position does not move
  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !refTick && slot <= lastSlot && !cfgWe) |=> ($stable(phase) && $stable(slot)));

  // R8: the blink phase only changes on a reference pulse
  p_blink_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !refTick && !cfgWe) |=> $stable(blinkOff));

  // R7: a disabled display restarts from the first half of slot 0
  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!phase && slot == 2'd0 && !blinkOff));

endmodule

// File: rtl/lcdSeqDatapath.sv
module lcdSeqDatapath
  import lcdSeqPkg::*;
#(
  parameter int NUM_SEG  = 8,
  parameter int ADDR_W   = 6,
  parameter int SEG_BASE = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [7:0]           wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [CFG_W-1:0]     cfgQ,
  input  seqState_t            st,
  output logic [7:0]           rdData,
  output logic [2*NUM_COM-1:0] comOut,
  output logic [2*NUM_SEG-1:0] segOut,
  output logic                 vlcEn
);

  logic [7:0]         segWord [NUM_SEG];
  logic [NUM_COM-1:0] comAtTop;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SEG; gi++) begin : g_store
      always_ff @(posedge clk) begin
        if (!rstN) segWord[gi] <= '0;
        else if (wrEn && wrAddr == ADDR_W'(SEG_BASE + gi)) segWord[gi] <= wrData;
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) rdData = {1'b0, cfgQ};
    for (int i = 0; i < NUM_SEG; i++)
      if (rdAddr == ADDR_W'(SEG_BASE + i)) rdData = segWord[i];
  end

  assign vlcEn = st.enable;

  // COM lines
  generate
    for (gi = 0; gi < NUM_COM; gi++) begin : g_com
      logic [1:0] lvl;
      always_comb begin
        if (!st.enable) begin
          lvl = LVL_GND;
        end else if (st.isStatic) begin
          lvl = (gi == 0) ? (st.phase ? LVL_GND : LVL_TOP) : LVL_GND;
        end else if (st.slot == 2'(gi)) begin
          lvl = st.phase ? LVL_GND : LVL_TOP;
        end else if (st.third) begin
          lvl = st.phase ? LVL_HI : LVL_LO;
        end else begin
          lvl = LVL_LO;
        end
      end
      assign comOut[2*gi +: 2] = lvl;
      assign comAtTop[gi]      = (lvl == LVL_TOP);
    end
  endgenerate

  // SEG lines
  generate
    for (gi = 0; gi < NUM_SEG; gi++) begin : g_seg
      logic       pixOn;
      logic [1:0] lvl;
      assign pixOn = segWord[gi][st.slot] && !(segWord[gi][4 + st.slot] && st.blinkOff);
      always_comb begin
        if (!st.enable)    lvl = LVL_GND;
        else if (st.third) lvl = st.phase ? (pixOn ? LVL_TOP : LVL_LO) : (pixOn ? LVL_GND : LVL_HI);
        else               lvl = st.phase ? (pixOn ? LVL_TOP : LVL_GND) : (pixOn ? LVL_GND : LVL_TOP);
      end
      assign segOut[2*gi +: 2] = lvl;
    end
  endgenerate

  // R7: a disabled display drives every line to ground
  p_dark_when_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !st.enable |-> (comOut == '0 && segOut == '0 && !vlcEn));

  // R6: at most one COM line is at full scale at any time
  p_one_top_com_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comAtTop));

  // R5: in static drive COM0 only swings between the rails
  p_static_rails_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.enable && st.isStatic) |-> (comOut[1:0] == LVL_GND || comOut[1:0] == LVL_TOP));

  // R4: at 1/2 bias no line uses the high intermediate level
  p_half_levels_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.enable && !st.third) |-> (comOut[1:0] != LVL_HI && segOut[1:0] != LVL_HI));

endmodule

// File: rtl/lcdWaveSeq.sv
module lcdWaveSeq
  import lcdSeqPkg::*;
#(
  parameter int NUM_SEG         = 8,
  parameter int ADDR_W          = 6,
  parameter int SEG_BASE        = 16,
  parameter int DIV_BASE_LOG2   = 9,
  parameter int BLINK_FAST_HALF = 16384,
  parameter int BLINK_SLOW_HALF = 32768
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refTick,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [7:0]           wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [7:0]           rdData,
  output logic [7:0]           comOut,
  output logic [2*NUM_SEG-1:0] segOut,
  output logic                 vlcEn
);

  logic             cfgWe;
  logic [CFG_W-1:0] cfgQ;
  seqState_t        st;

  assign cfgWe = wrEn && (wrAddr == '0);

  lcdSeqCtrl #(
    .DIV_BASE_LOG2  (DIV_BASE_LOG2),
    .BLINK_FAST_HALF(BLINK_FAST_HALF),
    .BLINK_SLOW_HALF(BLINK_SLOW_HALF)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .refTick  (refTick),
    .cfgWe    (cfgWe),
    .cfgWrData(wrData[CFG_W-1:0]),
    .cfgQ     (cfgQ),
    .st       (st)
  );

  lcdSeqDatapath #(
    .NUM_SEG (NUM_SEG),
    .ADDR_W  (ADDR_W),
    .SEG_BASE(SEG_BASE)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .cfgQ  (cfgQ),
    .st    (st),
    .rdData(rdData),
    .comOut(comOut),
    .segOut(segOut),
    .vlcEn (vlcEn)
  );

endmodule

// File: tb/lcdWaveSeq_tb.sv
module lcdWaveSeq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [5:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic [7:0]  comOut;
  logic [15:0] segOut;
  logic        vlcEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lcdWaveSeq dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .comOut(comOut),
    .segOut(segOut), .vlcEn(vlcEn)
  );

  // Vector fields: [10:8] mode, [7] pixel bit 0, [6] half, [5:4] COM0, [3:2] COM1, [1:0] SEG0
  localparam int NVEC = 13;
  localparam logic [10:0] VEC [NVEC] = '{
    {3'b000, 1'b1, 1'b0, 2'd3, 2'd1, 2'd0},
    {3'b000, 1'b0, 1'b0, 2'd3, 2'd1, 2'd2},
    {3'b000, 1'b1, 1'b1, 2'd0, 2'd2, 2'd3},
    {3'b000, 1'b0, 1'b1, 2'd0, 2'd2, 2'd1},
    {3'b010, 1'b1, 1'b0, 2'd3, 2'd1, 2'd0},
    {3'b010, 1'b0, 1'b0, 2'd3, 2'd1, 2'd3},
    {3'b010, 1'b1, 1'b1, 2'd0, 2'd1, 2'd3},
    {3'b010, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0},
    {3'b100, 1'b1, 1'b0, 2'd3, 2'd0, 2'd0},
    {3'b100, 1'b0, 1'b0, 2'd3, 2'd0, 2'd3},
    {3'b100, 1'b1, 1'b1, 2'd0, 2'd0, 2'd3},
    {3'b111, 1'b1, 1'b0, 2'd3, 2'd0, 2'd0},
    {3'b011, 1'b1, 1'b0, 2'd3, 2'd1, 2'd0}
  };

  function automatic logic [7:0] cfgByte(input logic [1:0] cs, input logic [2:0] md,
                                         input logic en, input logic slow);
    return {1'b0, slow, en, md, cs};
  endfunction

  function automatic logic [1:0] comAt(input int k);
    return comOut[2*k +: 2];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    refTick = 1'b1;
    repeat (n) @(negedge clk);
    refTick = 1'b0;
  endtask

  initial begin
    #1_400_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 comOut", comOut, 0);
    check("R11 segOut", segOut, 0);
    check("R11 vlcEn", vlcEn, 0);
    rdAddr = 6'd0;  #1 check("R11 cfg read", rdData, 0);
    rdAddr = 6'd16; #1 check("R11 seg read", rdData, 0);

    // R2 R3 R4 R5 level table
    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] v;
      v = VEC[i];
      wr(6'd0, cfgByte(2'd3, v[10:8], 1'b0, 1'b0));
      wr(6'd16, {7'b0, v[7]});
      wr(6'd0, cfgByte(2'd3, v[10:8], 1'b1, 1'b0));
      if (v[6]) ticks(64);
      check($sformatf("R2/R3/R4/R5 vec%0d COM0", i), comAt(0), int'(v[5:4]));
      check($sformatf("R2/R3/R4/R5 vec%0d COM1", i), comAt(1), int'(v[3:2]));
      check($sformatf("R2/R3/R4/R5 vec%0d SEG0", i), segOut[1:0], int'(v[1:0]));
    end

    // R6 slot order, mode 001 (3 slots, 1/3 bias), pixel word 0010
    wr(6'd0, cfgByte(2'd3, 3'b001, 1'b0, 1'b0));
    wr(6'd16, 8'h02);
    wr(6'd0, cfgByte(2'd3, 3'b001, 1'b1, 1'b0));
    check("R6 slot0 COM0", comAt(0), 3);
    check("R6 slot0 SEG off", segOut[1:0], 2);
    ticks(128);
    check("R6 slot1 COM1", comAt(1), 3);
    check("R6 slot1 COM0 unsel", comAt(0), 1);
    check("R6 slot1 SEG on", segOut[1:0], 0);
    ticks(128);
    check("R6 slot2 COM2", comAt(2), 3);
    check("R6 slot2 unused COM3", comAt(3), 1);
    check("R6 slot2 SEG off", segOut[1:0], 2);
    ticks(128);
    check("R6 wrap COM0", comAt(0), 3);

    // R6 four-slot mode reaches COM3
    wr(6'd0, cfgByte(2'd3, 3'b000, 1'b0, 1'b0));
    wr(6'd0, cfgByte(2'd3, 3'b000, 1'b1, 1'b0));
    ticks(384);
    check("R6 slot3 COM3", comAt(3), 3);

    // R1 divider ratios
    for (int cs = 0; cs < 4; cs++) begin
      int n;
      n = 512 >> cs;
      wr(6'd0, cfgByte(2'(cs), 3'b000, 1'b0, 1'b0));
      wr(6'd0, cfgByte(2'(cs), 3'b000, 1'b1, 1'b0));
      ticks(n - 1);
      check($sformatf("R1 sel%0d before edge", cs), comAt(0), 3);
      ticks(1);
      check($sformatf("R1 sel%0d at edge", cs), comAt(0), 0);
    end

    // R7 disable grounds everything and restarts
    wr(6'd0, cfgByte(2'd3, 3'b000, 1'b0, 1'b0));
    check("R7 com dark", comOut, 0);
    check("R7 seg dark", segOut, 0);
    check("R7 vlcEn low", vlcEn, 0);
    wr(6'd0, cfgByte(2'd3, 3'b000, 1'b1, 1'b0));
    check("R7 restart COM0", comAt(0), 3);
    check("R7 vlcEn high", vlcEn, 1);

    // R10 storage and ignored write
    wr(6'd21, 8'hA5);
    wr(6'd40, 8'hFF);
    wr(6'd0, cfgByte(2'd3, 3'b000, 1'b0, 1'b0));
    rdAddr = 6'd21; #1 check("R10 readback while off", rdData, 8'hA5);
    rdAddr = 6'd22; #1 check("R10 unmapped write ignored", rdData, 0);
    rdAddr = 6'd0;  #1 check("R10 cfg read", rdData, cfgByte(2'd3, 3'b000, 1'b0, 1'b0));

    // R8 blink at the fast rate, static mode: pixel on iff SEG0 differs from COM0
    wr(6'd16, 8'h11);
    wr(6'd0, cfgByte(2'd3, 3'b100, 1'b1, 1'b0));
    ticks(16383);
    check("R8 fast on before edge", segOut[1:0] != comAt(0), 1);
    ticks(1);
    check("R8 fast off at edge", segOut[1:0] != comAt(0), 0);
    ticks(16384);
    check("R8 fast on again", segOut[1:0] != comAt(0), 1);

    // R8 slow rate
    wr(6'd0, cfgByte(2'd3, 3'b100, 1'b0, 1'b1));
    wr(6'd0, cfgByte(2'd3, 3'b100, 1'b1, 1'b1));
    ticks(32767);
    check("R8 slow on before edge", segOut[1:0] != comAt(0), 1);
    ticks(1);
    check("R8 slow off at edge", segOut[1:0] != comAt(0), 0);

    // R9 mask on another COM, and data-off pixel
    wr(6'd16, 8'h21);
    wr(6'd17, 8'h10);
    wr(6'd0, cfgByte(2'd3, 3'b100, 1'b0, 1'b0));
    wr(6'd0, cfgByte(2'd3, 3'b100, 1'b1, 1'b0));
    ticks(16384);
    check("R9 other-COM mask no effect", segOut[1:0] != comAt(0), 1);
    check("R9 data-off pixel stays off", segOut[3:2] != comAt(0), 0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule